// File: doc/BRIEF.md
# ADC Result Holding Register with Read Interlock

This block holds the most recent 10-bit result from an analog-to-digital converter. Software reads it as two bytes on a simple register read bus. A mode input picks the layout. In truncated layout, only the eight most significant result bits appear, in the low byte, and the high byte reads as zero. In right-justified layout, the high byte carries the top two result bits and the low byte carries the bottom eight.

In right-justified layout, software reads the high byte first. That read freezes the stored result. Every later conversion is dropped until the low byte has been read, so the two bytes always come from the same conversion. A sticky overrun output reports that a result was dropped while the lock was held.

Read data is registered and appears one cycle after the read strobe. It holds its value between reads. There is no write path: nothing on the bus can alter the stored result.

Top module: `adc_result_hold`

## Requirements
- R1: After reset, reads of both bytes return 0x00 and `overrun` is 0.
- R2: With `mode_rj`=0 (truncated), a read of the low byte returns result bits 9..2, and a read of the high byte returns 0x00.
- R3: With `mode_rj`=0, every `conv_done` strobe replaces the stored result, and a high-byte read arms no lock.
- R4: With `mode_rj`=1 (right-justified), a high-byte read returns {6'b0, result[9:8]} and a low-byte read returns result[7:0].
- R5: With `mode_rj`=1, a high-byte read arms the lock. A `conv_done` in that same cycle, or in any later cycle while the lock is armed, is discarded.
- R6: A low-byte read releases the lock at the next clock edge. A `conv_done` in the same cycle as that read is still discarded, and the strobe after it is accepted.
- R7: `overrun` goes to 1 on the edge after a discarded result and stays 1. The releasing low-byte read clears it, unless a result is discarded in that same cycle, in which case it stays 1.
- R8: Any change of `mode_rj` clears the lock and `overrun` at the next edge. A `conv_done` in the cycle of the change is accepted.
- R9: The low byte sits at address `LO_ADDR` and the high byte at `LO_ADDR`+1. A read of any other address returns 0x00 and has no effect on the lock. `rd_data` is valid on the edge after `rd_en` and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 1 | Conversion-complete strobe, one cycle |
| conv_data | input | RES_W | Conversion result, sampled with `conv_done` |
| mode_rj | input | 1 | 0 = truncated layout, 1 = right-justified layout |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | ADDR_W | Bus read address |
| rd_data | output | BYTE_W | Registered read data |
| overrun | output | 1 | Sticky flag: a result was discarded by the lock |

## Verification
The main function is tried with result values that place different bits in the top two positions and in the bottom two. This separates a truncated layout from a right-justified one, and separates a correct shift from an off-by-one field. Lock behaviour is probed with strobes in several positions:
- strictly between the high-byte read and the low-byte read;
- in the very cycle of the high-byte read;
- in the very cycle of the releasing low-byte read;
- one cycle after that read.

These cases separate a lock that arms or releases one edge early or late from a correct one. Mode flips in the middle of a lock show whether the lock and the flag are cleared. Reads of a third address show that the address decode leaves the lock state alone.

// File: rtl/adc_hold_pkg.sv
package adc_hold_pkg;
  typedef enum logic { MODE_TRUNC = 1'b0, MODE_RJUST = 1'b1 } fmt_mode_e;
  typedef enum logic [1:0] { SEL_NONE = 2'd0, SEL_LO = 2'd1, SEL_HI = 2'd2 } byte_sel_e;
endpackage

// File: rtl/adc_hold_lock.sv
module adc_hold_lock
  import adc_hold_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  input  fmt_mode_e        mode,
  input  byte_sel_e        sel,
  output logic [RES_W-1:0] res_q,
  output logic             ovr_q
);
  fmt_mode_e mode_q;
  logic      lock_q;
  logic      mode_chg, hi_rd, lo_rd, block;

  assign mode_chg = (mode != mode_q);
  assign hi_rd    = (sel == SEL_HI);
  assign lo_rd    = (sel == SEL_LO);
  // the high read itself already shields the result it is returning
  assign block    = (mode == MODE_RJUST) && !mode_chg && (lock_q || hi_rd);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_TRUNC;
      lock_q <= 1'b0;
      ovr_q  <= 1'b0;
      res_q  <= '0;
    end else begin
      mode_q <= mode;
      if (conv_done && !block) res_q <= conv_data;
      if (mode_chg || mode == MODE_TRUNC) lock_q <= 1'b0;
      else if (lo_rd)                     lock_q <= 1'b0;
      else if (hi_rd)                     lock_q <= 1'b1;
      if (mode_chg)                ovr_q <= 1'b0;
      else if (conv_done && block) ovr_q <= 1'b1;
      else if (lo_rd && lock_q)    ovr_q <= 1'b0;
    end
  end

  a_r5_lock_holds: assert property (@(posedge clk) disable iff (rst)
    (lock_q && conv_done && !mode_chg) |=> $stable(res_q));
  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    (lock_q && lo_rd && !mode_chg) |=> !lock_q);
  a_r3_trunc_follow: assert property (@(posedge clk) disable iff (rst)
    (conv_done && mode == MODE_TRUNC) |=> (res_q == $past(conv_data)));
  a_r7_ovr_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_q) |-> $past(conv_done));
  a_r8_mode_clear: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> (!lock_q && !ovr_q));
endmodule

// File: rtl/adc_hold_rdfmt.sv
module adc_hold_rdfmt
  import adc_hold_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  byte_sel_e         sel,
  input  fmt_mode_e         mode,
  input  logic [RES_W-1:0]  res,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int HI_BITS = RES_W - BYTE_W;

  logic [BYTE_W-1:0] lo_v, hi_v;

  always_comb begin
    hi_v = '0;
    if (mode == MODE_RJUST) begin
      lo_v = res[BYTE_W-1:0];
      hi_v[HI_BITS-1:0] = res[RES_W-1:BYTE_W];
    end else begin
      lo_v = res[RES_W-1 -: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) begin
      case (sel)
        SEL_LO:  rd_data <= lo_v;
        SEL_HI:  rd_data <= hi_v;
        default: rd_data <= '0;
      endcase
    end
  end

  a_r2_hi_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_HI && mode == MODE_TRUNC) |=> (rd_data == '0));
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/adc_result_hold.sv
module adc_result_hold
  import adc_hold_pkg::*;
#(
  parameter int RES_W   = 10,
  parameter int BYTE_W  = 8,
  parameter int ADDR_W  = 8,
  parameter int LO_ADDR = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  input  logic              mode_rj,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              overrun
);
  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_ADDR);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(LO_ADDR + 1);

  fmt_mode_e        mode;
  byte_sel_e        sel;
  logic [RES_W-1:0] res_q;

  assign mode = mode_rj ? MODE_RJUST : MODE_TRUNC;

  always_comb begin
    sel = SEL_NONE;
    if (rd_en && rd_addr == LO_A)      sel = SEL_LO;
    else if (rd_en && rd_addr == HI_A) sel = SEL_HI;
  end

  adc_hold_lock #(.RES_W(RES_W)) u_lock (
    .clk(clk), .rst(rst), .conv_done(conv_done), .conv_data(conv_data),
    .mode(mode), .sel(sel), .res_q(res_q), .ovr_q(overrun)
  );

  adc_hold_rdfmt #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_rdfmt (
    .clk(clk), .rst(rst), .rd_en(rd_en), .sel(sel), .mode(mode),
    .res(res_q), .rd_data(rd_data)
  );
endmodule

// File: tb/test_adc_result_hold.sv
module test_adc_result_hold;
  localparam int CLK_PERIOD = 10;
  localparam int LO = 16;

  logic       clk = 0, rst = 1;
  logic       conv_done = 0, mode_rj = 0, rd_en = 0;
  logic [9:0] conv_data = '0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       overrun;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  // bench model
  logic [9:0] m_res = '0;
  logic m_lock = 0, m_ovr = 0, m_mode_prev = 0;
  logic [7:0] m_last = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_result_hold i_adc_result_hold (
    .clk(clk), .rst(rst), .conv_done(conv_done), .conv_data(conv_data),
    .mode_rj(mode_rj), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .overrun(overrun)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare registered read data the half cycle after the edge
  always begin
    @(posedge clk);
    if (rd_en && !rst) begin
      @(negedge clk);
      if (exp_q.size() > 0) chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  // which: 0 = low byte, 1 = high byte, 2 = unmapped address
  task automatic cyc(bit cv, logic [9:0] d, bit rd, int which, string tag);
    bit mchg, hi, lo, blk;
    logic [7:0] e;
    conv_done = cv; conv_data = d; rd_en = rd;
    rd_addr = (which == 0) ? 8'(LO) : (which == 1) ? 8'(LO + 1) : 8'(LO + 2);
    hi = rd && which == 1;
    lo = rd && which == 0;
    mchg = (mode_rj != m_mode_prev);
    if (rd) begin
      if (which == 0)      e = mode_rj ? m_res[7:0] : m_res[9:2];
      else if (which == 1) e = mode_rj ? {6'b0, m_res[9:8]} : 8'h00;
      else                 e = 8'h00;
      exp_q.push_back(e); tag_q.push_back(tag); m_last = e;
    end
    blk = mode_rj && !mchg && (m_lock || hi);
    if (mchg)              m_ovr = 0;
    else if (cv && blk)    m_ovr = 1;
    else if (lo && m_lock) m_ovr = 0;
    if (mchg || !mode_rj) m_lock = 0;
    else if (lo)          m_lock = 0;
    else if (hi)          m_lock = 1;
    if (cv && !blk) m_res = d;
    m_mode_prev = mode_rj;
    @(negedge clk);
    conv_done = 0; rd_en = 0;
  endtask

  task automatic chk_ovr(string tag);
    chk(tag, {7'b0, overrun}, {7'b0, m_ovr});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk_ovr("R1 overrun");
    cyc(0, 0, 1, 0, "R1 low reset");
    cyc(0, 0, 1, 1, "R1 high reset");
    // R2 truncated layout
    cyc(1, 10'h3A5, 0, 0, "");
    cyc(0, 0, 1, 0, "R2 trunc low");
    cyc(0, 0, 1, 1, "R2 trunc high");
    // R3 no lock in truncated mode
    cyc(1, 10'h155, 0, 0, "");
    cyc(0, 0, 1, 0, "R3 trunc update");
    chk_ovr("R3 no overrun");
    // R4 right-justified layout
    mode_rj = 1;
    cyc(1, 10'h2C7, 0, 0, "");
    cyc(0, 0, 1, 1, "R4 rj high");
    cyc(0, 0, 1, 0, "R4 rj low");
    // R5 lock between reads, R6 same-cycle release discard
    cyc(0, 0, 1, 1, "R5 high arms");
    cyc(1, 10'h0FF, 0, 0, "");
    chk_ovr("R7 overrun set");
    cyc(1, 10'h100, 0, 0, "");
    cyc(1, 10'h3FF, 1, 0, "R5 low frozen");
    chk_ovr("R7 set wins on release");
    cyc(1, 10'h201, 0, 0, "");
    cyc(0, 0, 1, 1, "R6 accepted after release");
    cyc(0, 0, 1, 0, "R6 accepted low");
    chk_ovr("R7 cleared by release");
    // R5 strobe in the same cycle as the high read
    cyc(1, 10'h3C3, 1, 1, "R5 high same-cycle");
    cyc(0, 0, 1, 0, "R5 same-cycle discard low");
    chk_ovr("R7 same-cycle overrun");
    // R7 clean release clears the flag
    cyc(0, 0, 1, 1, "R7 high");
    cyc(1, 10'h0AA, 0, 0, "");
    chk_ovr("R7 set");
    cyc(0, 0, 1, 0, "R7 low");
    chk_ovr("R7 cleared");
    // R8 mode change clears lock and flag
    cyc(0, 0, 1, 1, "R8 high arms");
    cyc(1, 10'h111, 0, 0, "");
    mode_rj = 0;
    cyc(1, 10'h2F0, 0, 0, "");
    chk_ovr("R8 flag cleared");
    cyc(0, 0, 1, 0, "R8 trunc low");
    cyc(0, 0, 1, 1, "R8 trunc high");
    mode_rj = 1;
    cyc(0, 0, 1, 1, "R8 high rj");
    mode_rj = 0;
    cyc(0, 0, 0, 0, "");
    mode_rj = 1;
    cyc(1, 10'h1E6, 0, 0, "");
    cyc(0, 0, 1, 0, "R8 lock gone low");
    // R9 unmapped address, no lock, and hold
    cyc(0, 0, 1, 2, "R9 unmapped zero");
    cyc(1, 10'h3D9, 0, 0, "");
    cyc(0, 0, 1, 0, "R9 no lock from unmapped");
    cyc(0, 0, 0, 0, "");
    cyc(1, 10'h000, 0, 0, "");
    chk("R9 hold", rd_data, m_last);
    chk_ovr("R9 overrun");
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule